// File: doc/BRIEF.md
# Four-Byte Serial Programming Command Decoder

This block is the target side of a serial programming link that is used while the chip is held in reset. A fast system clock oversamples the serial clock and the serial data input. The block gathers each instruction as four bytes and decodes the first byte, and the second byte where one is needed, into an operation. The operations are enable, chip erase, busy poll, page load, memory read, memory write, and access to the configuration fuse byte.

The memory-side controller sees a one-cycle request strobe carrying an operation code, two address bytes and a write data byte. It returns read data and a busy flag. The fuse byte lives in a small register inside the block. Read results and the busy flag are shifted out in the last byte of the frame.

The block ignores every instruction until an enable instruction has established frame alignment. When it runs in step with the host, the second enable byte comes back on the serial output while the third byte is being shifted in.

The link state machine has three states:
- `LNK_OFF`: programming mode is off.
- `LNK_HUNT`: enabled but not yet aligned.
- `LNK_SYNCED`: aligned and executing commands.

Its transitions:
- `LNK_OFF -> LNK_HUNT` when `prog_mode` rises.
- `LNK_HUNT -> LNK_SYNCED` at the end of a frame whose first two bytes are 0xAC 0x53.
- `LNK_SYNCED` holds through every other frame.
- Any state goes to `LNK_OFF` when `prog_mode` falls.

Top module: `isp_cmd_decoder`

## Requirements
- R1: While `prog_mode` is low, the block has these outputs one clock later: `miso_out` 0, no `mem_req`, the link state `LNK_OFF`. The bit counter, byte counter, captured bytes and output shifter are cleared, so a partial frame is discarded. After `prog_mode` returns high, commands are ignored until a new enable instruction completes.
- R2: Each instruction is exactly four bytes. Bits are taken most significant bit first from `mosi_in` at each rising edge of `sck_in`. The clock phases may be as short as 2 system clocks each, beyond the synchronizer.
- R3: `miso_out` changes only after a falling edge of `sck_in` and holds steady through the SCK high phase.
- R4: On `miso_out` the block sends the following bytes:
  - Byte 1 of every frame is 0x00.
  - Bytes 2 and 3 echo the first and second received bytes of the same frame.
  - During the enable instruction 0xAC 0x53 0x00 0x00, byte 3 therefore reads 0x53.
- R5: While the link is not synced, only a frame starting 0xAC 0x53 has an effect, which is to enter `LNK_SYNCED`. Any other frame raises no `mem_req`, leaves the fuse byte unchanged and returns 0x00 in byte 4.
- R6: Read instructions raise `mem_req` just after the 24th rising SCK edge of the frame:
  - 0x20 gives `mem_op` 5.
  - 0x28 gives `mem_op` 6.
  - 0xA0 gives `mem_op` 7.
  - `mem_addr_hi` is byte 2 and `mem_addr_lo` is byte 3.
  - Byte 4 out is `mem_rdata`, which must be valid from 2 clocks after the request.
- R7: The following instructions raise `mem_req` just after the 32nd rising SCK edge, with `mem_addr_hi` = byte 2, `mem_addr_lo` = byte 3 and `mem_wdata` = byte 4:
  - 0xAC 0x80 gives `mem_op` 1 (chip erase).
  - 0x40 gives `mem_op` 2 (load low byte).
  - 0x48 gives `mem_op` 3 (load high byte).
  - 0x4C gives `mem_op` 4 (write page).
  - 0xC0 gives `mem_op` 8 (EEPROM write).
- R8: The busy poll 0xF0 returns {7'b0, `mem_busy`} in byte 4 and raises no request.
- R9: Fuse write 0xAC 0xA0 stores byte 4 in the fuse register. Fuse read 0x50 0x00 returns that register in byte 4. The register resets to `FUSE_INIT`, which defaults to 0xE2.
- R10: Any other opcode, including 0xAC or 0x50 with an unlisted second byte, completes its four-byte frame with no request, no fuse change and 0x00 in byte 4. A repeated enable instruction while synced has no effect.
- R11: `mem_req` is high for exactly one clock, at most once per frame, and always carries a nonzero `mem_op`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x faster than SCK |
| rst_n | input | 1 | Asynchronous active-low reset |
| prog_mode | input | 1 | High while the chip is held in reset for programming |
| sck_in | input | 1 | Serial clock from the host, asynchronous |
| mosi_in | input | 1 | Serial data from the host |
| miso_out | output | 1 | Serial data to the host |
| mem_req | output | 1 | One-cycle memory operation strobe |
| mem_op | output | 4 | Operation code: 1 erase, 2 load low, 3 load high, 4 write page, 5 read low, 6 read high, 7 EEPROM read, 8 EEPROM write |
| mem_addr_hi | output | 8 | Address high byte (frame byte 2) |
| mem_addr_lo | output | 8 | Address low byte (frame byte 3) |
| mem_wdata | output | 8 | Write data (frame byte 4) |
| mem_rdata | input | 8 | Read data from the memory controller |
| mem_busy | input | 1 | High while a memory write is in progress |

## Verification
An SCK edge reaches the decoder logic two clocks after the host drives it. `miso_out` moves one clock after that, and `mem_req` appears on the same clock as the edge-detect register updates, three clocks after the rising edge is driven. The bench holds every SCK phase for four clocks and samples only at the clock just before it drives the next edge, so every result has settled. `miso_out` is sampled at the end of both the low and the high phase. Request logs are read after the last high phase of each frame, which ends a clock after the bench's memory model has recorded the strobe.

// File: rtl/isp_pkg.sv
package isp_pkg;

    localparam int BYTE_W      = 8;
    localparam int FRAME_BYTES = 4;
    localparam int BIT_W       = $clog2(BYTE_W);
    localparam int IDX_W       = $clog2(FRAME_BYTES);

    localparam logic [BYTE_W-1:0] OPC_SYS      = 8'hAC;
    localparam logic [BYTE_W-1:0] SUB_ENTER    = 8'h53;
    localparam logic [BYTE_W-1:0] SUB_ERASE    = 8'h80;
    localparam logic [BYTE_W-1:0] SUB_FUSE_WR  = 8'hA0;
    localparam logic [BYTE_W-1:0] OPC_POLL     = 8'hF0;
    localparam logic [BYTE_W-1:0] OPC_LOAD_LO  = 8'h40;
    localparam logic [BYTE_W-1:0] OPC_LOAD_HI  = 8'h48;
    localparam logic [BYTE_W-1:0] OPC_WR_PAGE  = 8'h4C;
    localparam logic [BYTE_W-1:0] OPC_RD_LO    = 8'h20;
    localparam logic [BYTE_W-1:0] OPC_RD_HI    = 8'h28;
    localparam logic [BYTE_W-1:0] OPC_EE_RD    = 8'hA0;
    localparam logic [BYTE_W-1:0] OPC_EE_WR    = 8'hC0;
    localparam logic [BYTE_W-1:0] OPC_FUSE_RD  = 8'h50;
    localparam logic [BYTE_W-1:0] SUB_FUSE_RD  = 8'h00;

    typedef enum logic [1:0] {
        LNK_OFF    = 2'd0,
        LNK_HUNT   = 2'd1,
        LNK_SYNCED = 2'd2
    } link_t;

    typedef enum logic [3:0] {
        CMD_NOP,
        CMD_ENABLE,
        CMD_ERASE,
        CMD_POLL,
        CMD_LOAD_LO,
        CMD_LOAD_HI,
        CMD_WRITE_PAGE,
        CMD_READ_LO,
        CMD_READ_HI,
        CMD_EE_READ,
        CMD_EE_WRITE,
        CMD_FUSE_WR,
        CMD_FUSE_RD
    } cmd_t;

    typedef enum logic [3:0] {
        MOP_NONE       = 4'd0,
        MOP_ERASE      = 4'd1,
        MOP_LOAD_LO    = 4'd2,
        MOP_LOAD_HI    = 4'd3,
        MOP_WRITE_PAGE = 4'd4,
        MOP_READ_LO    = 4'd5,
        MOP_READ_HI    = 4'd6,
        MOP_EE_READ    = 4'd7,
        MOP_EE_WRITE   = 4'd8
    } mop_t;

    function automatic cmd_t decode_cmd(input logic [BYTE_W-1:0] op,
                                        input logic [BYTE_W-1:0] sub);
        cmd_t c;
        c = CMD_NOP;
        case (op)
            OPC_SYS: begin
                if (sub == SUB_ENTER)        c = CMD_ENABLE;
                else if (sub == SUB_ERASE)   c = CMD_ERASE;
                else if (sub == SUB_FUSE_WR) c = CMD_FUSE_WR;
            end
            OPC_POLL:    c = CMD_POLL;
            OPC_LOAD_LO: c = CMD_LOAD_LO;
            OPC_LOAD_HI: c = CMD_LOAD_HI;
            OPC_WR_PAGE: c = CMD_WRITE_PAGE;
            OPC_RD_LO:   c = CMD_READ_LO;
            OPC_RD_HI:   c = CMD_READ_HI;
            OPC_EE_RD:   c = CMD_EE_READ;
            OPC_EE_WR:   c = CMD_EE_WRITE;
            OPC_FUSE_RD: if (sub == SUB_FUSE_RD) c = CMD_FUSE_RD;
            default:     c = CMD_NOP;
        endcase
        return c;
    endfunction

    function automatic mop_t cmd_to_mop(input cmd_t c);
        mop_t m;
        case (c)
            CMD_ERASE:      m = MOP_ERASE;
            CMD_LOAD_LO:    m = MOP_LOAD_LO;
            CMD_LOAD_HI:    m = MOP_LOAD_HI;
            CMD_WRITE_PAGE: m = MOP_WRITE_PAGE;
            CMD_READ_LO:    m = MOP_READ_LO;
            CMD_READ_HI:    m = MOP_READ_HI;
            CMD_EE_READ:    m = MOP_EE_READ;
            CMD_EE_WRITE:   m = MOP_EE_WRITE;
            default:        m = MOP_NONE;
        endcase
        return m;
    endfunction

    function automatic logic cmd_is_read(input cmd_t c);
        return (c == CMD_READ_LO) || (c == CMD_READ_HI) || (c == CMD_EE_READ);
    endfunction

    function automatic logic cmd_is_store(input cmd_t c);
        return (c == CMD_ERASE) || (c == CMD_LOAD_LO) || (c == CMD_LOAD_HI) ||
               (c == CMD_WRITE_PAGE) || (c == CMD_EE_WRITE);
    endfunction

endpackage

// File: rtl/isp_edge_sync.sv
module isp_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck_in,
    input  logic mosi_in,
    output logic sck_rise,
    output logic sck_fall,
    output logic mosi_smp
);

    logic [STAGES-1:0] sck_chain;
    logic [STAGES-1:0] mosi_chain;
    logic              sck_last;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    sck_chain  <= '0;
                    mosi_chain <= '0;
                end else begin
                    sck_chain  <= sck_in;
                    mosi_chain <= mosi_in;
                end
            end
        end else begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    sck_chain  <= '0;
                    mosi_chain <= '0;
                end else begin
                    sck_chain  <= {sck_chain[STAGES-2:0], sck_in};
                    mosi_chain <= {mosi_chain[STAGES-2:0], mosi_in};
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sck_last <= 1'b0;
        else        sck_last <= sck_chain[STAGES-1];
    end

    assign sck_rise = sck_chain[STAGES-1] & ~sck_last;
    assign sck_fall = ~sck_chain[STAGES-1] & sck_last;
    assign mosi_smp = mosi_chain[STAGES-1];

endmodule

// File: rtl/isp_shift_unit.sv
module isp_shift_unit
    import isp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              rise,
    input  logic              fall,
    input  logic              mosi_smp,
    input  logic [BYTE_W-1:0] tx_byte,
    output logic              byte_done,
    output logic [BYTE_W-1:0] byte_val,
    output logic [IDX_W-1:0]  byte_idx,
    output logic              miso
);

    localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(BYTE_W - 1);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(FRAME_BYTES - 1);

    logic [BIT_W-1:0]  bit_q;
    logic [IDX_W-1:0]  idx_q;
    logic [BYTE_W-1:0] rx_q;
    logic [BYTE_W-1:0] tx_q;

    assign byte_done = rise && (bit_q == BIT_LAST);
    assign byte_val  = {rx_q[BYTE_W-2:0], mosi_smp};
    assign byte_idx  = idx_q;
    assign miso      = tx_q[BYTE_W-1];

    // receive side: counters advance on each rising SCK edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_q <= '0;
            idx_q <= '0;
            rx_q  <= '0;
        end else if (clr) begin
            bit_q <= '0;
            idx_q <= '0;
            rx_q  <= '0;
        end else if (rise) begin
            rx_q  <= byte_val;
            bit_q <= (bit_q == BIT_LAST) ? '0 : bit_q + 1'b1;
            if (bit_q == BIT_LAST)
                idx_q <= (idx_q == IDX_LAST) ? '0 : idx_q + 1'b1;
        end
    end

    // transmit side: loads at a byte boundary, shifts otherwise
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_q <= '0;
        end else if (clr) begin
            tx_q <= '0;
        end else if (fall) begin
            if (bit_q == '0) tx_q <= tx_byte;
            else             tx_q <= {tx_q[BYTE_W-2:0], 1'b0};
        end
    end

endmodule

// File: rtl/isp_cmd_fsm.sv
module isp_cmd_fsm
    import isp_pkg::*;
#(
    parameter logic [7:0] FUSE_INIT = 8'hE2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prog_mode,
    input  logic              byte_done,
    input  logic [BYTE_W-1:0] byte_val,
    input  logic [IDX_W-1:0]  byte_idx,
    input  logic [BYTE_W-1:0] mem_rdata,
    input  logic              mem_busy,
    output logic [BYTE_W-1:0] tx_byte,
    output link_t             link_st,
    output logic              mem_req,
    output logic [3:0]        mem_op,
    output logic [BYTE_W-1:0] mem_addr_hi,
    output logic [BYTE_W-1:0] mem_addr_lo,
    output logic [BYTE_W-1:0] mem_wdata
);

    localparam logic [IDX_W-1:0] IDX_B3 = IDX_W'(FRAME_BYTES - 2);
    localparam logic [IDX_W-1:0] IDX_B4 = IDX_W'(FRAME_BYTES - 1);

    link_t             link_q, link_d;
    logic [BYTE_W-1:0] b1_q, b2_q, b3_q;
    logic [BYTE_W-1:0] fuse_q;
    cmd_t              cmd_now;
    logic              frame_end;
    logic              synced;
    logic              req_q;
    mop_t              op_q;
    logic [BYTE_W-1:0] hi_q, lo_q, wd_q;

    assign cmd_now   = decode_cmd(b1_q, b2_q);
    assign frame_end = byte_done && (byte_idx == IDX_B4);
    assign synced    = (link_q == LNK_SYNCED);

    // captured frame bytes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            b1_q <= '0;
            b2_q <= '0;
            b3_q <= '0;
        end else if (!prog_mode) begin
            b1_q <= '0;
            b2_q <= '0;
            b3_q <= '0;
        end else if (byte_done) begin
            unique case (byte_idx)
                2'd0:    b1_q <= byte_val;
                2'd1:    b2_q <= byte_val;
                2'd2:    b3_q <= byte_val;
                default: ;
            endcase
        end
    end

    // link state: next-state logic
    always_comb begin
        link_d = link_q;
        unique case (link_q)
            LNK_OFF:    if (prog_mode) link_d = LNK_HUNT;
            LNK_HUNT:   if (frame_end && b1_q == OPC_SYS && b2_q == SUB_ENTER)
                            link_d = LNK_SYNCED;
            LNK_SYNCED: link_d = LNK_SYNCED;
            default:    link_d = LNK_OFF;
        endcase
        if (!prog_mode) link_d = LNK_OFF;
    end

    // link state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) link_q <= LNK_OFF;
        else        link_q <= link_d;
    end

    // outputs: memory strobe, address, data and fuse register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_q  <= 1'b0;
            op_q   <= MOP_NONE;
            hi_q   <= '0;
            lo_q   <= '0;
            wd_q   <= '0;
            fuse_q <= FUSE_INIT;
        end else begin
            req_q <= 1'b0;
            if (!prog_mode) begin
                op_q <= MOP_NONE;
                hi_q <= '0;
                lo_q <= '0;
                wd_q <= '0;
            end else if (byte_done && synced) begin
                if (byte_idx == IDX_B3 && cmd_is_read(cmd_now)) begin
                    req_q <= 1'b1;
                    op_q  <= cmd_to_mop(cmd_now);
                    hi_q  <= b2_q;
                    lo_q  <= byte_val;
                    wd_q  <= '0;
                end else if (byte_idx == IDX_B4 && cmd_is_store(cmd_now)) begin
                    req_q <= 1'b1;
                    op_q  <= cmd_to_mop(cmd_now);
                    hi_q  <= b2_q;
                    lo_q  <= b3_q;
                    wd_q  <= byte_val;
                end
                if (byte_idx == IDX_B4 && cmd_now == CMD_FUSE_WR)
                    fuse_q <= byte_val;
            end
        end
    end

    // outgoing byte for the index about to be shifted
    always_comb begin
        tx_byte = '0;
        unique case (byte_idx)
            2'd0: tx_byte = '0;
            2'd1: tx_byte = b1_q;
            2'd2: tx_byte = b2_q;
            2'd3: begin
                if (synced) begin
                    unique case (cmd_now)
                        CMD_POLL:    tx_byte = {{(BYTE_W-1){1'b0}}, mem_busy};
                        CMD_READ_LO,
                        CMD_READ_HI,
                        CMD_EE_READ: tx_byte = mem_rdata;
                        CMD_FUSE_RD: tx_byte = fuse_q;
                        default:     tx_byte = '0;
                    endcase
                end
            end
            default: tx_byte = '0;
        endcase
    end

    assign link_st     = link_q;
    assign mem_req     = req_q;
    assign mem_op      = op_q;
    assign mem_addr_hi = hi_q;
    assign mem_addr_lo = lo_q;
    assign mem_wdata   = wd_q;

endmodule

// File: rtl/isp_cmd_decoder.sv
module isp_cmd_decoder #(
    parameter int         SYNC_STAGES = 2,
    parameter logic [7:0] FUSE_INIT   = 8'hE2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       prog_mode,
    input  logic       sck_in,
    input  logic       mosi_in,
    output logic       miso_out,
    output logic       mem_req,
    output logic [3:0] mem_op,
    output logic [7:0] mem_addr_hi,
    output logic [7:0] mem_addr_lo,
    output logic [7:0] mem_wdata,
    input  logic [7:0] mem_rdata,
    input  logic       mem_busy
);

    import isp_pkg::*;

    logic              sck_rise;
    logic              sck_fall;
    logic              mosi_smp;
    logic              byte_done;
    logic [BYTE_W-1:0] byte_val;
    logic [IDX_W-1:0]  byte_idx;
    logic [BYTE_W-1:0] tx_byte;
    link_t             link_st;

    isp_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .sck_in   (sck_in),
        .mosi_in  (mosi_in),
        .sck_rise (sck_rise),
        .sck_fall (sck_fall),
        .mosi_smp (mosi_smp)
    );

    isp_shift_unit u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (!prog_mode),
        .rise      (sck_rise),
        .fall      (sck_fall),
        .mosi_smp  (mosi_smp),
        .tx_byte   (tx_byte),
        .byte_done (byte_done),
        .byte_val  (byte_val),
        .byte_idx  (byte_idx),
        .miso      (miso_out)
    );

    isp_cmd_fsm #(.FUSE_INIT(FUSE_INIT)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .prog_mode   (prog_mode),
        .byte_done   (byte_done),
        .byte_val    (byte_val),
        .byte_idx    (byte_idx),
        .mem_rdata   (mem_rdata),
        .mem_busy    (mem_busy),
        .tx_byte     (tx_byte),
        .link_st     (link_st),
        .mem_req     (mem_req),
        .mem_op      (mem_op),
        .mem_addr_hi (mem_addr_hi),
        .mem_addr_lo (mem_addr_lo),
        .mem_wdata   (mem_wdata)
    );

endmodule

// File: rtl/isp_cmd_decoder_chk.sv
module isp_cmd_decoder_chk
    import isp_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       prog_mode,
    input logic       sck_rise,
    input logic       sck_fall,
    input link_t      link_st,
    input logic       miso_out,
    input logic       mem_req,
    input logic [3:0] mem_op
);

    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !prog_mode |=> (!miso_out && !mem_req && link_st == LNK_OFF)); // R1

    AST_MISO_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_mode && $past(prog_mode) && !$stable(miso_out)) |-> $past(sck_fall)); // R3

    AST_REQ_NEEDS_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (link_st == LNK_SYNCED)); // R5

    AST_REQ_AFTER_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> $past(sck_rise)); // R6

    AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req); // R11

    AST_REQ_OP_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_op != 4'd0)); // R11

endmodule

bind isp_cmd_decoder isp_cmd_decoder_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .prog_mode (prog_mode),
    .sck_rise  (sck_rise),
    .sck_fall  (sck_fall),
    .link_st   (link_st),
    .miso_out  (miso_out),
    .mem_req   (mem_req),
    .mem_op    (mem_op)
);

// File: tb/sim_isp_cmd_decoder.sv
`timescale 1ns/1ps
module sim_isp_cmd_decoder;

    localparam int         HALF      = 4;
    localparam logic [7:0] FUSE_DEF  = 8'hE2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       prog_mode = 1'b0;
    logic       sck = 1'b0;
    logic       mosi = 1'b0;
    logic       miso;
    logic       mem_req;
    logic [3:0] mem_op;
    logic [7:0] mem_addr_hi, mem_addr_lo, mem_wdata;
    logic [7:0] mem_rdata = 8'h00;
    logic       mem_busy = 1'b0;

    int errors = 0;
    int checks = 0;
    int miso_glitch = 0;
    bit done = 0;

    int         req_cnt = 0;
    logic [3:0] last_op = 4'd0;
    logic [7:0] last_hi = 8'd0, last_lo = 8'd0, last_wd = 8'd0;

    always #2 clk = ~clk;   // 250 MHz

    isp_cmd_decoder u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .prog_mode   (prog_mode),
        .sck_in      (sck),
        .mosi_in     (mosi),
        .miso_out    (miso),
        .mem_req     (mem_req),
        .mem_op      (mem_op),
        .mem_addr_hi (mem_addr_hi),
        .mem_addr_lo (mem_addr_lo),
        .mem_wdata   (mem_wdata),
        .mem_rdata   (mem_rdata),
        .mem_busy    (mem_busy)
    );

    function automatic logic [7:0] rd_fn(input logic [3:0] op, input logic [7:0] hi,
                                         input logic [7:0] lo);
        return (lo ^ 8'h3C) + hi + {4'h0, op};
    endfunction

    // memory controller model: answers one clock after each strobe
    always_ff @(posedge clk) begin
        if (mem_req) begin
            req_cnt   <= req_cnt + 1;
            last_op   <= mem_op;
            last_hi   <= mem_addr_hi;
            last_lo   <= mem_addr_lo;
            last_wd   <= mem_wdata;
            mem_rdata <= rd_fn(mem_op, mem_addr_hi, mem_addr_lo);
        end
    end

    // expected memory op per the requirement tables (R6, R7)
    function automatic logic [3:0] exp_mop(input logic [7:0] b1, input logic [7:0] b2);
        if (b1 == 8'hAC && b2 == 8'h80) return 4'd1;
        case (b1)
            8'h40: return 4'd2;
            8'h48: return 4'd3;
            8'h4C: return 4'd4;
            8'h20: return 4'd5;
            8'h28: return 4'd6;
            8'hA0: return 4'd7;
            8'hC0: return 4'd8;
            default: return 4'd0;
        endcase
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bits(input logic [31:0] tx, input int nbits, output logic [31:0] rx);
        logic lo_smp;
        rx = '0;
        for (int i = 31; i > 31 - nbits; i--) begin
            sck  = 1'b0;
            mosi = tx[i];
            wait_clk(HALF);
            lo_smp = miso;
            rx[i]  = lo_smp;
            sck    = 1'b1;
            wait_clk(HALF);
            if (miso !== lo_smp) miso_glitch++;
        end
    endtask

    task automatic frame(input logic [7:0] b1, b2, b3, b4, output logic [31:0] rx);
        send_bits({b1, b2, b3, b4}, 32, rx);
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL R2 watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] rx;
        int          base;
        logic [3:0]  m;
        logic [7:0]  e4;

        wait_clk(5);
        check("R1 reset miso", int'(miso), 0);
        check("R1 reset req", int'(mem_req), 0);
        rst_n = 1'b1;
        wait_clk(3);
        check("R1 off miso", int'(miso), 0);
        prog_mode = 1'b1;
        wait_clk(4);

        // unsynced: write ignored, echo still works
        base = req_cnt;
        frame(8'hC0, 8'h01, 8'h02, 8'h03, rx);
        check("R5 unsynced no req", req_cnt - base, 0);
        check("R5 unsynced byte4", int'(rx[7:0]), 0);
        check("R4 echo byte2 unsynced", int'(rx[23:16]), 8'hC0);

        // wrong enable second byte: stays unsynced
        frame(8'hAC, 8'h52, 8'h00, 8'h00, rx);
        check("R4 echo 0x52", int'(rx[15:8]), 8'h52);
        base = req_cnt;
        frame(8'h28, 8'h00, 8'h10, 8'h00, rx);
        check("R5 bad enable no req", req_cnt - base, 0);

        // good enable
        frame(8'hAC, 8'h53, 8'h00, 8'h00, rx);
        check("R4 enable byte1", int'(rx[31:24]), 0);
        check("R4 enable echo 0x53", int'(rx[15:8]), 8'h53);

        // EEPROM write
        base = req_cnt;
        frame(8'hC0, 8'h00, 8'h21, 8'h5E, rx);
        check("R7 ee write count", req_cnt - base, 1);
        check("R7 ee write op", int'(last_op), 8);
        check("R7 ee write lo", int'(last_lo), 8'h21);
        check("R7 ee write data", int'(last_wd), 8'h5E);

        // read high with nonzero high address
        base = req_cnt;
        frame(8'h28, 8'h13, 8'h77, 8'h00, rx);
        check("R6 read count", req_cnt - base, 1);
        check("R6 read op", int'(last_op), 6);
        check("R6 read hi", int'(last_hi), 8'h13);
        check("R6 read data", int'(rx[7:0]), int'(rd_fn(4'd6, 8'h13, 8'h77)));

        // busy poll
        mem_busy = 1'b1;
        base = req_cnt;
        frame(8'hF0, 8'h00, 8'h00, 8'h00, rx);
        check("R8 poll busy", int'(rx[7:0]), 1);
        check("R8 poll no req", req_cnt - base, 0);
        mem_busy = 1'b0;
        frame(8'hF0, 8'h00, 8'h00, 8'h00, rx);
        check("R8 poll idle", int'(rx[7:0]), 0);

        // fuse register
        frame(8'h50, 8'h00, 8'h00, 8'h00, rx);
        check("R9 fuse default", int'(rx[7:0]), int'(FUSE_DEF));
        frame(8'hAC, 8'hA0, 8'h00, 8'h5B, rx);
        frame(8'h50, 8'h00, 8'h00, 8'h00, rx);
        check("R9 fuse written", int'(rx[7:0]), 8'h5B);
        frame(8'h50, 8'h08, 8'h00, 8'h00, rx);
        check("R10 fuse read bad sub", int'(rx[7:0]), 0);

        // chip erase and repeated enable
        base = req_cnt;
        frame(8'hAC, 8'h80, 8'h00, 8'h00, rx);
        check("R7 erase op", int'(last_op), 1);
        frame(8'hAC, 8'h53, 8'h00, 8'h00, rx);
        check("R10 re-enable no req", req_cnt - base, 1);

        // sweep all first bytes while synced
        for (int op = 0; op < 256; op++) begin
            logic [7:0] b1, b3, b4;
            b1 = 8'(op);
            b3 = b1 ^ 8'hA5;
            b4 = ~b1;
            m  = exp_mop(b1, 8'h00);
            if (m >= 4'd5 && m <= 4'd7)   e4 = rd_fn(m, 8'h00, b3);
            else if (b1 == 8'h50)         e4 = 8'h5B;
            else                          e4 = 8'h00;
            base = req_cnt;
            frame(b1, 8'h00, b3, b4, rx);
            check("R4 sweep byte1", int'(rx[31:24]), 0);
            check("R4 sweep echo b1", int'(rx[23:16]), int'(b1));
            check("R2 sweep echo b2", int'(rx[15:8]), 0);
            check("R10 sweep byte4", int'(rx[7:0]), int'(e4));
            check("R11 sweep req count", req_cnt - base, (m != 0) ? 1 : 0);
            if (m != 0) begin
                check("R7 sweep op", int'(last_op), int'(m));
                check("R7 sweep lo", int'(last_lo), int'(b3));
                if (m < 4'd5 || m > 4'd7)
                    check("R7 sweep wdata", int'(last_wd), int'(b4));
            end
        end

        // leave programming mode mid-frame
        send_bits(32'h2800_0000, 12, rx);
        prog_mode = 1'b0;
        wait_clk(2);
        check("R1 drop miso", int'(miso), 0);
        sck = 1'b0;
        wait_clk(HALF);
        prog_mode = 1'b1;
        wait_clk(HALF);
        base = req_cnt;
        frame(8'h20, 8'h00, 8'h05, 8'h00, rx);
        check("R1 sync lost", req_cnt - base, 0);
        frame(8'hAC, 8'h53, 8'h00, 8'h00, rx);
        check("R2 realigned echo", int'(rx[15:8]), 8'h53);
        frame(8'h20, 8'h00, 8'h05, 8'h00, rx);
        check("R6 read after resync", int'(rx[7:0]), int'(rd_fn(4'd5, 8'h00, 8'h05)));

        check("R3 miso stable while high", miso_glitch, 0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule